// File: doc/BRIEF.md
# Alarm Comparator with Status Flags

This block holds a 24-bit BCD alarm setting made of four fields: minutes, hours, day of month and month. A fixed number of slow-clock ticks after each minute boundary, it compares the alarm setting with the live time-of-day fields. When the two are equal, it sets a sticky match flag. That flag drives a dedicated output and also stays visible to software until a bus command clears it. A date-mask flag limits the comparison to minutes and hours only, so that a daily alarm can be set.

The block also keeps a sticky power-fail flag. Two mode inputs choose where the failure indication comes from: the on-chip detector level, an external active-low line, a test setting, or no source at all. Once the flag is set, it stays set after the failure goes away. It is cleared only by a write transaction that uses the execute-address command. The time counter, the bus decoder and the analog detector are outside this block. Each one reaches it through single-cycle strobes or levels.

Top module: `alarm_flags`

## Requirements
- R1: An alarm write with `alm_sel_i` 0 (minutes), 1 (hours), 2 (day) or 3 (month) loads the low 7, 6, 6 or 5 bits of `alm_wdata_i` into that field. `alm_rdata_o` returns the selected field with the upper bits read as zero. Writing 0xFF to hours reads back 0x3F, and writing 0xFF to month reads back 0x1F.
- R2: A `min_edge_i` pulse starts a delay of DELAY_TICKS (default 131) `tick_en_i` cycles. The match is evaluated in the cycle after the last of those ticks, and a match sets `comp_o` one clock later. `comp_o` does not change before that point.
- R3: When `noda_o` is 0, `comp_o` is set only if all four fields are equal. A difference in day or month alone prevents the set.
- R4: When `noda_o` is 1, only minutes and hours are compared. Day and month differences are ignored, and a minute difference still prevents the set.
- R5: `comp_o` stays at 1 through later evaluations that do not match. A `clr_comp_i` pulse clears it on the next clock.
- R6: If `clr_comp_i` arrives in the same cycle as a matching evaluation, the set wins and `comp_o` stays at 1.
- R7: `noda_o` resets to 0. `set_noda_i` sets it and `clr_noda_i` clears it. If both arrive together, it is set.
- R8: `powf_o` resets to 1. An `exec_wr_i` pulse clears it, provided no failure is sensed in that cycle.
- R9: In mode {ext_mode_i,pfin_i}=00, a high `pf_det_i` sets `powf_o` on the next clock. The flag stays set after `pf_det_i` returns low.
- R10: When `ext_mode_i`=1, `pfin_i` low sets `powf_o` and `pfin_i` high senses no failure. `pf_det_i` has no effect in this mode.
- R11: In mode 01 (test), `powf_o` is forced to 0 and `test_det_o` follows `pf_det_i`. In every other mode, `test_det_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | 32.768 kHz tick enable |
| min_edge_i | input | 1 | Minute boundary pulse |
| time_min_i | input | 7 | Current minutes, BCD |
| time_hour_i | input | 6 | Current hours, BCD |
| time_day_i | input | 6 | Current day, BCD |
| time_mon_i | input | 5 | Current month, BCD |
| alm_wr_i | input | 1 | Alarm field write strobe |
| alm_sel_i | input | 2 | Alarm field select |
| alm_wdata_i | input | 8 | Alarm write data |
| clr_comp_i | input | 1 | Clear match flag command |
| set_noda_i | input | 1 | Set date-mask command |
| clr_noda_i | input | 1 | Clear date-mask command |
| exec_wr_i | input | 1 | Execute-address write received |
| pf_det_i | input | 1 | Internal detector level, high = fail |
| ext_mode_i | input | 1 | Power-fail source select |
| pfin_i | input | 1 | External power-fail line / mode bit |
| alm_rdata_o | output | 8 | Selected alarm field, zero-extended |
| comp_o | output | 1 | Latched match flag and pin |
| noda_o | output | 1 | Date-mask flag |
| powf_o | output | 1 | Latched power-fail flag |
| test_det_o | output | 1 | Detector level exposed in test mode |

## Verification
A vector table runs pairs of alarm and time settings through full minute boundaries. The pairs include an exact match, a mismatch in a single field (day, month, minute or hour), and the same pairs with the date mask on and off. Together these separate a full 24-bit compare from the minutes-and-hours compare. Each boundary samples `comp_o` both in the evaluation cycle and one cycle later, which pins the delay to exactly the programmed tick count. Directed sequences cover clear-versus-set collisions, masked field widths, and each of the four power-fail modes with the detector and the external line toggled against one another.

// File: rtl/alarm_pkg.sv
`timescale 1ns/1ps
package alarm_pkg;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int DAY_W  = 6;
  localparam int MON_W  = 5;
  localparam int ALM_W  = MIN_W + HOUR_W + DAY_W + MON_W;

  typedef enum logic [1:0] {
    FLD_MIN  = 2'd0,
    FLD_HOUR = 2'd1,
    FLD_DAY  = 2'd2,
    FLD_MON  = 2'd3
  } fld_e;

  typedef struct packed {
    logic [MON_W-1:0]  mon;
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
  } alarm_t;

  typedef enum logic [1:0] {
    PF_INTERNAL = 2'b00,
    PF_TEST     = 2'b01,
    PF_EXT_LOW  = 2'b10,
    PF_NONE     = 2'b11
  } pf_mode_e;
endpackage

// File: rtl/alarm_store.sv
`timescale 1ns/1ps
module alarm_store
  import alarm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] sel_i,
  input  logic [7:0] wdata_i,
  output alarm_t     alarm_o,
  output logic [7:0] rdata_o
);
  alarm_t alarm_q;
  logic   unused_msb;

  assign unused_msb = wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
    end else if (wr_i) begin
      unique case (fld_e'(sel_i))
        FLD_MIN:  alarm_q.min  <= wdata_i[MIN_W-1:0];
        FLD_HOUR: alarm_q.hour <= wdata_i[HOUR_W-1:0];
        FLD_DAY:  alarm_q.day  <= wdata_i[DAY_W-1:0];
        default:  alarm_q.mon  <= wdata_i[MON_W-1:0];
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (fld_e'(sel_i))
      FLD_MIN:  rdata_o[MIN_W-1:0]  = alarm_q.min;
      FLD_HOUR: rdata_o[HOUR_W-1:0] = alarm_q.hour;
      FLD_DAY:  rdata_o[DAY_W-1:0]  = alarm_q.day;
      default:  rdata_o[MON_W-1:0]  = alarm_q.mon;
    endcase
  end

  assign alarm_o = alarm_q;
endmodule

// File: rtl/match_timer.sv
`timescale 1ns/1ps
module match_timer #(
  parameter int DELAY_TICKS = 131
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic min_edge_i,
  input  logic tick_i,
  output logic eval_o
);
  localparam int CNT_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             eval_q;

  // a fresh minute edge restarts any pending count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      eval_q  <= 1'b0;
    end else begin
      eval_q <= 1'b0;
      if (min_edge_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (armed_q && tick_i) begin
        if (cnt_q == LAST) begin
          armed_q <= 1'b0;
          eval_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign eval_o = eval_q;
endmodule

// File: rtl/power_flag.sv
`timescale 1ns/1ps
module power_flag
  import alarm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_mode_i,
  input  logic pfin_i,
  input  logic pf_det_i,
  input  logic exec_wr_i,
  output logic powf_o,
  output logic test_det_o
);
  pf_mode_e mode_w;
  logic     fail_w;
  logic     test_w;
  logic     powf_q;

  assign mode_w = pf_mode_e'({ext_mode_i, pfin_i});

  always_comb begin
    fail_w = 1'b0;
    test_w = 1'b0;
    unique case (mode_w)
      PF_INTERNAL: fail_w = pf_det_i;
      PF_TEST:     test_w = 1'b1;
      PF_EXT_LOW:  fail_w = 1'b1;   // external line sensed low
      default:     fail_w = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        powf_q <= 1'b1;
    else if (test_w)    powf_q <= 1'b0;
    else if (fail_w)    powf_q <= 1'b1;
    else if (exec_wr_i) powf_q <= 1'b0;
  end

  assign powf_o     = powf_q;
  assign test_det_o = test_w & pf_det_i;
endmodule

// File: rtl/alarm_flags.sv
`timescale 1ns/1ps
module alarm_flags
  import alarm_pkg::*;
#(
  parameter int DELAY_TICKS = 131
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              min_edge_i,
  input  logic [MIN_W-1:0]  time_min_i,
  input  logic [HOUR_W-1:0] time_hour_i,
  input  logic [DAY_W-1:0]  time_day_i,
  input  logic [MON_W-1:0]  time_mon_i,
  input  logic              alm_wr_i,
  input  logic [1:0]        alm_sel_i,
  input  logic [7:0]        alm_wdata_i,
  input  logic              clr_comp_i,
  input  logic              set_noda_i,
  input  logic              clr_noda_i,
  input  logic              exec_wr_i,
  input  logic              pf_det_i,
  input  logic              ext_mode_i,
  input  logic              pfin_i,
  output logic [7:0]        alm_rdata_o,
  output logic              comp_o,
  output logic              noda_o,
  output logic              powf_o,
  output logic              test_det_o
);
  alarm_t alarm_w;
  alarm_t now_w;
  logic   eval_w;
  logic   hm_eq_w;
  logic   date_eq_w;
  logic   hit_w;
  logic   comp_q;
  logic   noda_q;

  alarm_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (alm_wr_i),
    .sel_i   (alm_sel_i),
    .wdata_i (alm_wdata_i),
    .alarm_o (alarm_w),
    .rdata_o (alm_rdata_o)
  );

  match_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .min_edge_i (min_edge_i),
    .tick_i     (tick_en_i),
    .eval_o     (eval_w)
  );

  power_flag u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_mode_i (ext_mode_i),
    .pfin_i     (pfin_i),
    .pf_det_i   (pf_det_i),
    .exec_wr_i  (exec_wr_i),
    .powf_o     (powf_o),
    .test_det_o (test_det_o)
  );

  assign now_w     = '{mon: time_mon_i, day: time_day_i, hour: time_hour_i, min: time_min_i};
  assign hm_eq_w   = (alarm_w.min == now_w.min) && (alarm_w.hour == now_w.hour);
  assign date_eq_w = (alarm_w.day == now_w.day) && (alarm_w.mon == now_w.mon);
  assign hit_w     = hm_eq_w && (noda_q || date_eq_w);

  // set beats a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               comp_q <= 1'b0;
    else if (eval_w && hit_w)  comp_q <= 1'b1;
    else if (clr_comp_i)       comp_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         noda_q <= 1'b0;
    else if (set_noda_i) noda_q <= 1'b1;
    else if (clr_noda_i) noda_q <= 1'b0;
  end

  assign comp_o = comp_q;
  assign noda_o = noda_q;
endmodule

// File: rtl/alarm_flags_chk.sv
`timescale 1ns/1ps
module alarm_flags_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic eval_i,
  input logic clr_comp_i,
  input logic set_noda_i,
  input logic clr_noda_i,
  input logic exec_wr_i,
  input logic ext_mode_i,
  input logic pfin_i,
  input logic comp_o,
  input logic noda_o,
  input logic powf_o,
  input logic test_det_o
);
  p_comp_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(comp_o) |-> $past(eval_i));

  p_eval_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |=> !eval_i);

  p_comp_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(comp_o) |-> $past(clr_comp_i));

  p_noda_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_noda_i |=> noda_o);

  p_noda_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_noda_i && !set_noda_i) |=> !noda_o);

  p_powf_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(powf_o) |-> ($past(exec_wr_i) || $past(!ext_mode_i && pfin_i)));

  p_ext_fail_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode_i && !pfin_i) |=> powf_o);

  p_test_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_mode_i && pfin_i) |=> !powf_o);

  p_test_out_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ext_mode_i && pfin_i) |-> !test_det_o);
endmodule

bind alarm_flags alarm_flags_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .eval_i     (eval_w),
  .clr_comp_i (clr_comp_i),
  .set_noda_i (set_noda_i),
  .clr_noda_i (clr_noda_i),
  .exec_wr_i  (exec_wr_i),
  .ext_mode_i (ext_mode_i),
  .pfin_i     (pfin_i),
  .comp_o     (comp_o),
  .noda_o     (noda_o),
  .powf_o     (powf_o),
  .test_det_o (test_det_o)
);

// File: tb/alarm_flags_tb.sv
`timescale 1ns/1ps
module alarm_flags_tb;
  localparam int DELAY = 131;

  typedef struct packed {
    logic [7:0] a_min, a_hour, a_day, a_mon;
    logic [7:0] t_min, t_hour, t_day, t_mon;
    logic       noda;
    logic       exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'h30, 8'h12, 8'h15, 8'h06, 8'h30, 8'h12, 8'h15, 8'h06, 1'b0, 1'b1},
    '{8'h30, 8'h12, 8'h15, 8'h06, 8'h30, 8'h12, 8'h16, 8'h06, 1'b0, 1'b0},
    '{8'h30, 8'h12, 8'h15, 8'h06, 8'h30, 8'h12, 8'h16, 8'h06, 1'b1, 1'b1},
    '{8'h30, 8'h12, 8'h15, 8'h06, 8'h31, 8'h12, 8'h15, 8'h06, 1'b1, 1'b0},
    '{8'h59, 8'h23, 8'h31, 8'h12, 8'h59, 8'h23, 8'h31, 8'h12, 1'b0, 1'b1},
    '{8'h59, 8'h23, 8'h31, 8'h12, 8'h59, 8'h23, 8'h31, 8'h11, 1'b0, 1'b0},
    '{8'h00, 8'h07, 8'h01, 8'h01, 8'h00, 8'h08, 8'h01, 8'h01, 1'b1, 1'b0},
    '{8'h00, 8'h07, 8'h01, 8'h01, 8'h00, 8'h07, 8'h28, 8'h09, 1'b1, 1'b1}
  };

  logic       clk_i = 0, rst_ni = 0;
  logic       tick_en_i = 0, min_edge_i = 0;
  logic [6:0] time_min_i = 0;
  logic [5:0] time_hour_i = 0, time_day_i = 0;
  logic [4:0] time_mon_i = 0;
  logic       alm_wr_i = 0;
  logic [1:0] alm_sel_i = 0;
  logic [7:0] alm_wdata_i = 0;
  logic       clr_comp_i = 0, set_noda_i = 0, clr_noda_i = 0, exec_wr_i = 0;
  logic       pf_det_i = 0, ext_mode_i = 1, pfin_i = 1;
  logic [7:0] alm_rdata_o;
  logic       comp_o, noda_o, powf_o, test_det_o;

  int errors = 0, checks = 0;
  logic before_c, after_c;

  always #5 clk_i = ~clk_i;

  alarm_flags #(.DELAY_TICKS(DELAY)) u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_alarm(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk_i); alm_wr_i = 1; alm_sel_i = sel; alm_wdata_i = d;
    @(negedge clk_i); alm_wr_i = 0;
  endtask

  task automatic clear_comp();
    @(negedge clk_i); clr_comp_i = 1;
    @(negedge clk_i); clr_comp_i = 0;
  endtask

  task automatic noda_cmd(input logic s, input logic c);
    @(negedge clk_i); set_noda_i = s; clr_noda_i = c;
    @(negedge clk_i); set_noda_i = 0; clr_noda_i = 0;
  endtask

  task automatic exec_pulse();
    @(negedge clk_i); exec_wr_i = 1;
    @(negedge clk_i); exec_wr_i = 0;
  endtask

  task automatic boundary(input logic clr_at_eval, output logic b, output logic a);
    @(negedge clk_i); min_edge_i = 1; tick_en_i = 0;
    @(negedge clk_i); min_edge_i = 0; tick_en_i = 1;
    repeat (DELAY) @(negedge clk_i);
    b = comp_o;
    clr_comp_i = clr_at_eval;
    @(negedge clk_i);
    tick_en_i = 0; clr_comp_i = 0;
    a = comp_o;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // reset state
    check("R2 reset comp", comp_o, 0);
    check("R7 reset noda", noda_o, 0);
    check("R8 reset powf", powf_o, 1);
    check("R11 reset test_det", test_det_o, 0);

    // R8 clear by execute write
    exec_pulse();
    check("R8 exec clears powf", powf_o, 0);

    // R1 masked widths
    wr_alarm(2'd1, 8'hFF); alm_sel_i = 2'd1; #1;
    check("R1 hours masked", alm_rdata_o, 8'h3F);
    wr_alarm(2'd3, 8'hFF); alm_sel_i = 2'd3; #1;
    check("R1 month masked", alm_rdata_o, 8'h1F);
    wr_alarm(2'd0, 8'hFF); alm_sel_i = 2'd0; #1;
    check("R1 minutes masked", alm_rdata_o, 8'h7F);
    wr_alarm(2'd2, 8'h2A); alm_sel_i = 2'd2; #1;
    check("R1 day", alm_rdata_o, 8'h2A);

    // vector walk: R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      clear_comp();
      if (VEC[i].noda) noda_cmd(1, 0); else noda_cmd(0, 1);
      wr_alarm(2'd0, VEC[i].a_min);
      wr_alarm(2'd1, VEC[i].a_hour);
      wr_alarm(2'd2, VEC[i].a_day);
      wr_alarm(2'd3, VEC[i].a_mon);
      time_min_i  = VEC[i].t_min[6:0];
      time_hour_i = VEC[i].t_hour[5:0];
      time_day_i  = VEC[i].t_day[5:0];
      time_mon_i  = VEC[i].t_mon[4:0];
      boundary(0, before_c, after_c);
      check($sformatf("R2 no early set vec%0d", i), before_c, 0);
      check($sformatf("%s vec%0d", VEC[i].noda ? "R4" : "R3", i), after_c, VEC[i].exp);
    end

    // R6 clear coincident with a matching evaluation
    noda_cmd(0, 1);
    wr_alarm(2'd0, 8'h45); wr_alarm(2'd1, 8'h09);
    wr_alarm(2'd2, 8'h10); wr_alarm(2'd3, 8'h03);
    time_min_i = 7'h45; time_hour_i = 6'h09; time_day_i = 6'h10; time_mon_i = 5'h03;
    clear_comp();
    boundary(1, before_c, after_c);
    check("R6 set wins over clear", after_c, 1);

    // R5 latch across a non-matching minute, then clear
    time_min_i = 7'h46;
    boundary(0, before_c, after_c);
    check("R5 stays latched", after_c, 1);
    clear_comp();
    check("R5 clear drops comp", comp_o, 0);

    // R7 commands
    noda_cmd(1, 0); check("R7 set", noda_o, 1);
    noda_cmd(0, 1); check("R7 clear", noda_o, 0);
    noda_cmd(1, 1); check("R7 both sets", noda_o, 1);

    // R9 internal detector
    ext_mode_i = 0; pfin_i = 0; pf_det_i = 0;
    exec_pulse();
    check("R9 no fail", powf_o, 0);
    @(negedge clk_i); pf_det_i = 1;
    @(negedge clk_i); pf_det_i = 0;
    check("R9 detector sets", powf_o, 1);
    @(negedge clk_i);
    check("R9 latched", powf_o, 1);
    check("R11 no test out", test_det_o, 0);
    exec_pulse();
    check("R8 exec clears after recovery", powf_o, 0);

    // R8 exec while failing
    @(negedge clk_i); pf_det_i = 1; exec_wr_i = 1;
    @(negedge clk_i); exec_wr_i = 0; pf_det_i = 0;
    check("R8 fail beats exec", powf_o, 1);
    exec_pulse();

    // R10 external line
    @(negedge clk_i); ext_mode_i = 1; pfin_i = 1; pf_det_i = 1;
    @(negedge clk_i);
    check("R10 detector ignored", powf_o, 0);
    pfin_i = 0;
    @(negedge clk_i);
    check("R10 low line sets", powf_o, 1);
    pfin_i = 1; pf_det_i = 0;
    @(negedge clk_i);
    check("R10 latched", powf_o, 1);
    exec_pulse();
    check("R10 exec clears", powf_o, 0);

    // R11 test mode
    @(negedge clk_i); ext_mode_i = 0; pfin_i = 1; pf_det_i = 1;
    #1;
    check("R11 test_det follows", test_det_o, 1);
    @(negedge clk_i);
    check("R11 powf held clear", powf_o, 0);
    pf_det_i = 0; #1;
    check("R11 test_det low", test_det_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule